// File: doc/BRIEF.md
# Cascadable synchronous up/down counter

This block is one stage of a presettable binary counter. Its default width is 4 bits. It steps up or down by one on each rising clock edge. All state bits sit in one register and share one clock, so every output bit changes at the same edge. No bit is clocked by another bit.

The stage has an active-low synchronous preset that takes its value from a parallel data bus. It has two active-low count enables. Both enables must be low for the stage to count. The second enable, called the chain enable, also gates the active-low carry output. That output is combinational. It goes low while the chain enable is low and the count is at its terminal value. The terminal value is all ones when counting up and all zeros when counting down.

To build a wider synchronous counter, wire the carry output of each stage to the chain enable of the next stage. Every stage shares the clock, the preset strobe, the direction select and the free-running count enable. No extra gating is needed.

Top module: `updn_count_stage`

## Requirements
- R1: All count bits change together on a single rising clock edge. For example, counting up from 7 gives 8 directly after one edge, with no intermediate value.
- R2: When `load_n` is 0 at a rising edge, `q` takes the value of `din` after that edge. The levels of `cnt_en_n`, `chain_en_n` and `up` are ignored for that edge.
- R3: When `load_n`=1, `cnt_en_n`=0, `chain_en_n`=0 and `up`=1 at an edge, `q` becomes `q`+1. The value 15 wraps to 0.
- R4: When `load_n`=1, `cnt_en_n`=0, `chain_en_n`=0 and `up`=0 at an edge, `q` becomes `q`-1. The value 0 wraps to 15.
- R5: When `load_n`=1 and at least one of `cnt_en_n` or `chain_en_n` is 1 at an edge, `q` keeps its value.
- R6: `carry_n` is 0 exactly when `chain_en_n`=0 and either `up`=1 with `q`=15, or `up`=0 with `q`=0. It follows its inputs within the same cycle, with no register on the path.
- R7: Two stages form an 8-bit synchronous counter when wired this way:
  - the low stage's `carry_n` drives the high stage's `chain_en_n`;
  - the high stage holds the upper nibble;
  - the two stages share `clk`, `load_n`, `up` and `cnt_en_n`.
  
  The pair then counts up or down modulo 256. The high stage's `carry_n` is 0 at 255 when counting up and at 0 when counting down.
- R8: Changes on `load_n`, `din`, `cnt_en_n`, `chain_en_n` or `up` between clock edges leave `q` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state bits |
| load_n | input | 1 | Active-low synchronous preset strobe |
| din | input | W | Parallel preset value |
| up | input | 1 | Direction select: 1 counts up, 0 counts down |
| cnt_en_n | input | 1 | Active-low count enable that does not gate the carry |
| chain_en_n | input | 1 | Active-low count enable that also gates `carry_n` |
| q | output | W | Current count |
| carry_n | output | 1 | Active-low terminal-count carry for chaining |

## Verification
The stage has no reset. Its state is unknown until the first preset. The assertions therefore stay disabled for their first two clock edges, and they assume that the stimulus keeps `load_n` low during that window.

The bench always opens with a preset and holds `din` and all controls at known levels from time zero. This keeps every `$past` value defined. The bench then changes inputs only at falling edges, so each assertion samples settled, known values.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } step_op_e;

endpackage

// File: rtl/updn_op_decode.sv
module updn_op_decode
  import updn_pkg::*;
(
  input  logic     load_n,
  input  logic     cnt_en_n,
  input  logic     chain_en_n,
  input  logic     up,
  output step_op_e op
);

  logic counting;

  assign counting = ~cnt_en_n & ~chain_en_n;

  // Preset wins over counting; enables are don't-care while load_n is low.
  always_comb begin
    if (!load_n)       op = OP_LOAD;
    else if (!counting) op = OP_HOLD;
    else if (up)        op = OP_INC;
    else                op = OP_DEC;
  end

endmodule

// File: rtl/updn_next_value.sv
module updn_next_value
  import updn_pkg::*;
#(
  parameter int W = 4
) (
  input  step_op_e     op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_INC:  nxt = cur + ONE;
      OP_DEC:  nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/updn_terminal_flag.sv
module updn_terminal_flag #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  input  logic         chain_en_n,
  output logic         carry_n
);

  logic at_top;
  logic at_bottom;
  logic at_end;

  assign at_top    = &cur;
  assign at_bottom = ~|cur;
  assign at_end    = up ? at_top : at_bottom;
  assign carry_n   = ~(at_end & ~chain_en_n);

endmodule

// File: rtl/updn_count_stage.sv
module updn_count_stage
  import updn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         up,
  input  logic         cnt_en_n,
  input  logic         chain_en_n,
  output logic [W-1:0] q,
  output logic         carry_n
);

  step_op_e     op;
  logic [W-1:0] nxt;
  logic [W-1:0] cnt_q;

  updn_op_decode u_decode (
    .load_n     (load_n),
    .cnt_en_n   (cnt_en_n),
    .chain_en_n (chain_en_n),
    .up         (up),
    .op         (op)
  );

  updn_next_value #(.W(W)) u_next (
    .op  (op),
    .cur (cnt_q),
    .din (din),
    .nxt (nxt)
  );

  // Single register: every bit shares the one clock edge.
  always_ff @(posedge clk) begin
    cnt_q <= nxt;
  end

  updn_terminal_flag #(.W(W)) u_term (
    .cur        (cnt_q),
    .up         (up),
    .chain_en_n (chain_en_n),
    .carry_n    (carry_n)
  );

  assign q = cnt_q;

endmodule

// File: rtl/updn_count_stage_chk.sv
module updn_count_stage_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         load_n,
  input logic [W-1:0] din,
  input logic         up,
  input logic         cnt_en_n,
  input logic         chain_en_n,
  input logic [W-1:0] q,
  input logic         carry_n
);

  localparam logic [W-1:0] ONE = W'(1);

  // No reset exists; checks start once two edges (preset) have passed.
  logic [1:0] prime_q = 2'b00;
  always_ff @(posedge clk) prime_q <= {prime_q[0], 1'b1};

  logic armed;
  assign armed = prime_q[1];

  AST_PRESET_TAKES_DIN: assert property (@(posedge clk) disable iff (!armed)
    !load_n |=> q == $past(din)); // R2

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!armed)
    (load_n && !cnt_en_n && !chain_en_n && up) |=> q == W'($past(q) + ONE)); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!armed)
    (load_n && !cnt_en_n && !chain_en_n && !up) |=> q == W'($past(q) - ONE)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!armed)
    (load_n && (cnt_en_n || chain_en_n)) |=> $stable(q)); // R5

  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!armed)
    chain_en_n |-> carry_n); // R6

  AST_CARRY_AT_END: assert property (@(posedge clk) disable iff (!armed)
    !carry_n |-> (up ? (q == {W{1'b1}}) : (q == '0))); // R6

endmodule

bind updn_count_stage updn_count_stage_chk #(.W(W)) u_chk (
  .clk        (clk),
  .load_n     (load_n),
  .din        (din),
  .up         (up),
  .cnt_en_n   (cnt_en_n),
  .chain_en_n (chain_en_n),
  .q          (q),
  .carry_n    (carry_n)
);

// File: tb/updn_count_stage_tb.sv
module updn_count_stage_tb;

  logic       clk = 1'b0;
  logic       load_n = 1'b0;
  logic [3:0] d_lo = 4'd0;
  logic [3:0] d_hi = 4'd0;
  logic       up = 1'b1;
  logic       enp_n = 1'b1;
  logic       ent_n = 1'b1;
  logic [3:0] q_lo, q_hi;
  logic       rco_lo, rco_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] ref_v = 8'd0;

  always #10 clk = ~clk;

  updn_count_stage #(.W(4)) u_dut (
    .clk(clk), .load_n(load_n), .din(d_lo), .up(up),
    .cnt_en_n(enp_n), .chain_en_n(ent_n), .q(q_lo), .carry_n(rco_lo)
  );

  updn_count_stage #(.W(4)) u_hi (
    .clk(clk), .load_n(load_n), .din(d_hi), .up(up),
    .cnt_en_n(enp_n), .chain_en_n(rco_lo), .q(q_hi), .carry_n(rco_hi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at falling edge, check carries mid-cycle, then the count after the edge.
  task automatic apply(input logic ln, input logic [3:0] dl, input logic [3:0] dh,
                       input logic ep, input logic et, input logic u, input bit full);
    logic exp_lo_c, exp_hi_c;
    string tag;
    @(negedge clk);
    load_n = ln; d_lo = dl; d_hi = dh; enp_n = ep; ent_n = et; up = u;
    #2;
    exp_lo_c = !(!et && (u ? ref_v[3:0] == 4'hF : ref_v[3:0] == 4'h0));
    exp_hi_c = !(!et && (u ? ref_v == 8'hFF : ref_v == 8'h00));
    chk(rco_lo == exp_lo_c, "R6 low carry", int'(rco_lo), int'(exp_lo_c));
    if (full) chk(rco_hi == exp_hi_c, "R7 high carry", int'(rco_hi), int'(exp_hi_c));
    if (!ln)            begin ref_v = {dh, dl}; tag = "R2 preset"; end
    else if (ep || et)  tag = "R5 hold";
    else if (u)         begin ref_v = ref_v + 8'd1; tag = "R3 up"; end
    else                begin ref_v = ref_v - 8'd1; tag = "R4 down"; end
    @(posedge clk);
    #2;
    chk(q_lo == ref_v[3:0], tag, int'(q_lo), int'(ref_v[3:0]));
    if (full) chk({q_hi, q_lo} == ref_v, "R7 cascade", int'({q_hi, q_lo}), int'(ref_v));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Initial preset (state known after this)
    apply(1'b0, 4'd5, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    apply(1'b0, 4'd5, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(q_lo == 4'd5, "R2 initial preset", int'(q_lo), 5);

    // Exhaustive single-stage sweep: every start value, every control combination
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        apply(1'b0, 4'(s), 4'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        apply(c[3], ~4'(s), 4'd0, c[2], c[1], c[0], 1'b0);
      end
    end

    // R1: every bit flips in one edge (7 -> 8 and 8 -> 7)
    apply(1'b0, 4'd7, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    apply(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(q_lo == 4'd8, "R1 simultaneous up", int'(q_lo), 8);
    apply(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(q_lo == 4'd7, "R1 simultaneous down", int'(q_lo), 7);

    // R8: control changes between edges do not touch the count
    @(negedge clk);
    load_n = 1'b0; d_lo = 4'd12; enp_n = 1'b0; ent_n = 1'b0; up = 1'b0;
    #3;
    chk(q_lo == 4'd7, "R8 mid-cycle preset request", int'(q_lo), 7);
    up = 1'b1; load_n = 1'b1;
    #2;
    chk(q_lo == 4'd7, "R8 mid-cycle count request", int'(q_lo), 7);
    enp_n = 1'b1; ent_n = 1'b1;
    @(posedge clk);
    #2;
    chk(q_lo == 4'd7, "R8 hold after withdrawn requests", int'(q_lo), 7);

    // R7: two-stage cascade against an 8-bit reference, presets mid-run
    apply(1'b0, 4'hA, 4'hF, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 1200; i++) begin
      logic ln, ep, et, u;
      ln = !((i % 97) == 50);
      u  = ((i / 300) % 2) == 0;
      ep = (i % 11) == 3;
      et = (i % 13) == 7;
      apply(ln, 4'(i * 7), 4'(i * 3), ep, et, u, 1'b1);
    end
    // Wrap corners across the whole pair
    apply(1'b0, 4'hF, 4'hF, 1'b1, 1'b1, 1'b1, 1'b1);
    apply(1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk({q_hi, q_lo} == 8'h00, "R7 wrap up 255->0", int'({q_hi, q_lo}), 0);
    apply(1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk({q_hi, q_lo} == 8'hFF, "R7 wrap down 0->255", int'({q_hi, q_lo}), 255);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule